// File: doc/BRIEF.md
# Shifted Register Move Unit

This block performs the execute step of a register-to-register move whose source passes through an immediate shifter on the way. Each clock it accepts one decoded operation: a source value, a shift kind, a shift amount, the current carry flag, a set-flags bit, a destination register index and a condition-passed bit. One cycle later it presents the shifted result together with the commit strobes a core needs: a general register write, a program-counter write or an exception return, and the next N, Z and C flags with their own write strobe.

The shifter gives the carry-out of the shift. A zero amount passes the carry through. The right shifts reach a full word width. The rotate kind with a zero amount means rotate-right-with-extend. A destination index equal to the program counter's index never touches the flags. It takes the plain PC-write path when set-flags is clear and the exception-return path when set-flags is set. Decode and the register file sit outside the block.

Top module: `shift_move_unit`

## Requirements
- R1: When cond_pass is 0, one cycle later rf_wr, pc_wr, exc_ret and flg_wr are all 0 and flg_n, flg_z, flg_c keep their previous values.
- R2: With cond_pass 1 and dst_idx not equal to PC_IDX (15 by default), one cycle later rf_wr is 1, pc_wr and exc_ret are 0, and flg_wr equals set_flags.
- R3: With cond_pass 1, dst_idx equal to PC_IDX and set_flags 0, one cycle later pc_wr is 1 and rf_wr, exc_ret and flg_wr are 0.
- R4: With cond_pass 1, dst_idx equal to PC_IDX and set_flags 1, one cycle later exc_ret is 1 and rf_wr, pc_wr and flg_wr are 0.
- R5: When flg_wr is 1, flg_n is bit DW-1 of res_q, flg_z is 1 exactly when res_q is all zeros, and flg_c is the shifter carry-out. When flg_wr is 0 the three flags hold. No overflow flag is produced.
- R6: sh_kind encodes 0 = LSL, 1 = LSR, 2 = ASR, 3 = ROR. For LSL, LSR or ASR with sh_amt 0, the result equals src_val and the carry-out equals carry_in.
- R7: LSL by n in 1..31 gives src_val shifted left by n with zero fill, and the carry-out is src_val bit 32-n.
- R8: LSR by n in 1..32 gives a zero-filled right shift, with carry-out src_val bit n-1. At n = 32 the result is zero and the carry-out is src_val bit 31.
- R9: ASR by n in 1..32 gives a sign-filled right shift, with carry-out src_val bit n-1. At n = 32 every result bit and the carry-out equal src_val bit 31.
- R10: ROR by n in 1..31 rotates src_val right by n, and the carry-out equals result bit 31.
- R11: ROR with sh_amt 0 is rotate-right-with-extend: the result is {carry_in, src_val[31:1]} and the carry-out is src_val bit 0.
- R12: Every output is registered. res_q shows the result of the inputs sampled at the previous rising edge. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_pass | input | 1 | Operation's condition passed |
| set_flags | input | 1 | Operation requests a flag update |
| dst_idx | input | IDXW | Destination register index |
| sh_kind | input | 2 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| sh_amt | input | AW | Shift amount, 0..DW |
| src_val | input | DW | Source operand |
| carry_in | input | 1 | Current carry flag |
| res_q | output | DW | Registered result |
| rf_wr | output | 1 | General register write strobe |
| pc_wr | output | 1 | Plain program-counter write strobe |
| exc_ret | output | 1 | Exception-return strobe carrying res_q |
| flg_wr | output | 1 | Flag write strobe |
| flg_n | output | 1 | Negative flag |
| flg_z | output | 1 | Zero flag |
| flg_c | output | 1 | Carry flag |

## Verification
The bench sweeps every legal amount of every shift kind over operands with the sign bit set, clear, alternating and sparse, each with both carry-in values. This covers the amount-0 pass-through, the 32-place right shifts, and the swap of rotate-by-zero into rotate-with-extend. A shifter that indexes the carry bit off by one, or that treats LSR #32 as a zero shift, would show a wrong flg_c or res_q. A rotate that ignores carry_in would corrupt bit 31 on extend. A second sweep walks every destination index against set_flags and cond_pass. This catches a design that updates flags on a PC write, raises two commit strobes at once, or lets a failed condition disturb the held flags.

// File: rtl/shmv_pkg.sv
`timescale 1ns/1ps
package shmv_pkg;

  // Shift kind encoding; a decoder upstream depends on these values.
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

endpackage

// File: rtl/shmv_shifter.sv
`timescale 1ns/1ps
module shmv_shifter #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  shmv_pkg::shift_kind_e kind,
  input  logic [AW-1:0]         amt,
  input  logic [DW-1:0]         x,
  input  logic                  ci,
  output logic [DW-1:0]         res,
  output logic                  cout
);
  import shmv_pkg::*;

  // Each helper returns {carry_out, result}.
  function automatic logic [DW:0] f_lsl(input logic [DW-1:0] v, input int n, input logic c);
    if (n == 0)  return {c, v};
    if (n > DW)  return '0;
    if (n == DW) return {v[0], {DW{1'b0}}};
    return {v[DW-n], v << n};
  endfunction

  function automatic logic [DW:0] f_lsr(input logic [DW-1:0] v, input int n, input logic c);
    if (n == 0)  return {c, v};
    if (n > DW)  return '0;
    if (n == DW) return {v[DW-1], {DW{1'b0}}};
    return {v[n-1], v >> n};
  endfunction

  function automatic logic [DW:0] f_asr(input logic [DW-1:0] v, input int n, input logic c);
    logic [DW-1:0] t;
    if (n == 0)  return {c, v};
    if (n >= DW) return {v[DW-1], {DW{v[DW-1]}}};
    t = $unsigned($signed(v) >>> n);
    return {v[n-1], t};
  endfunction

  function automatic logic [DW:0] f_ror(input logic [DW-1:0] v, input int n, input logic c);
    logic [DW-1:0] r;
    int m;
    if (n == 0) return {v[0], c, v[DW-1:1]};
    m = n % DW;
    r = (v >> m) | (v << (DW - m));
    return {r[DW-1], r};
  endfunction

  logic [DW:0] pick;
  int          n_i;

  always_comb begin
    n_i = int'(amt);
    unique case (kind)
      SK_LSL:  pick = f_lsl(x, n_i, ci);
      SK_LSR:  pick = f_lsr(x, n_i, ci);
      SK_ASR:  pick = f_asr(x, n_i, ci);
      default: pick = f_ror(x, n_i, ci);
    endcase
  end

  assign res  = pick[DW-1:0];
  assign cout = pick[DW];

endmodule

// File: rtl/shmv_commit.sv
`timescale 1ns/1ps
module shmv_commit #(
  parameter int DW     = 32,
  parameter int IDXW   = 4,
  parameter int PC_IDX = 15
) (
  input  logic            cond_pass,
  input  logic            set_flags,
  input  logic [IDXW-1:0] dst_idx,
  input  logic [DW-1:0]   res,
  input  logic            cout,
  output logic            rf_wr,
  output logic            pc_wr,
  output logic            exc_ret,
  output logic            flg_wr,
  output logic            nxt_n,
  output logic            nxt_z,
  output logic            nxt_c
);
  localparam logic [IDXW-1:0] PC_CODE = IDXW'(PC_IDX);

  function automatic logic f_all_zero(input logic [DW-1:0] v);
    return ~|v;
  endfunction

  logic to_pc;
  assign to_pc   = (dst_idx == PC_CODE);
  assign rf_wr   = cond_pass & ~to_pc;
  assign pc_wr   = cond_pass &  to_pc & ~set_flags;
  assign exc_ret = cond_pass &  to_pc &  set_flags;
  assign flg_wr  = cond_pass & ~to_pc &  set_flags;
  assign nxt_n   = res[DW-1];
  assign nxt_z   = f_all_zero(res);
  assign nxt_c   = cout;

endmodule

// File: rtl/shift_move_unit.sv
`timescale 1ns/1ps
module shift_move_unit #(
  parameter int DW     = 32,
  parameter int IDXW   = 4,
  parameter int PC_IDX = 15,
  localparam int AW    = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cond_pass,
  input  logic            set_flags,
  input  logic [IDXW-1:0] dst_idx,
  input  logic [1:0]      sh_kind,
  input  logic [AW-1:0]   sh_amt,
  input  logic [DW-1:0]   src_val,
  input  logic            carry_in,
  output logic [DW-1:0]   res_q,
  output logic            rf_wr,
  output logic            pc_wr,
  output logic            exc_ret,
  output logic            flg_wr,
  output logic            flg_n,
  output logic            flg_z,
  output logic            flg_c
);
  import shmv_pkg::*;

  // Named internal events, visible to the bound checker.
  shift_kind_e   kind_e;
  logic [DW-1:0] sh_res;
  logic          sh_cout;
  logic          rf_wr_d, pc_wr_d, exc_ret_d, flg_wr_d;
  logic          nxt_n, nxt_z, nxt_c;

  assign kind_e = shift_kind_e'(sh_kind);

  shmv_shifter #(.DW(DW), .AW(AW)) u_shift (
    .kind (kind_e),
    .amt  (sh_amt),
    .x    (src_val),
    .ci   (carry_in),
    .res  (sh_res),
    .cout (sh_cout)
  );

  shmv_commit #(.DW(DW), .IDXW(IDXW), .PC_IDX(PC_IDX)) u_commit (
    .cond_pass (cond_pass),
    .set_flags (set_flags),
    .dst_idx   (dst_idx),
    .res       (sh_res),
    .cout      (sh_cout),
    .rf_wr     (rf_wr_d),
    .pc_wr     (pc_wr_d),
    .exc_ret   (exc_ret_d),
    .flg_wr    (flg_wr_d),
    .nxt_n     (nxt_n),
    .nxt_z     (nxt_z),
    .nxt_c     (nxt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      rf_wr   <= 1'b0;
      pc_wr   <= 1'b0;
      exc_ret <= 1'b0;
      flg_wr  <= 1'b0;
      flg_n   <= 1'b0;
      flg_z   <= 1'b0;
      flg_c   <= 1'b0;
    end else begin
      res_q   <= sh_res;
      rf_wr   <= rf_wr_d;
      pc_wr   <= pc_wr_d;
      exc_ret <= exc_ret_d;
      flg_wr  <= flg_wr_d;
      if (flg_wr_d) begin
        flg_n <= nxt_n;
        flg_z <= nxt_z;
        flg_c <= nxt_c;
      end
    end
  end

endmodule

// File: rtl/shmv_chk.sv
`timescale 1ns/1ps
module shmv_chk #(
  parameter int DW     = 32,
  parameter int IDXW   = 4,
  parameter int PC_IDX = 15,
  parameter int AW     = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            cond_pass,
  input logic            set_flags,
  input logic [IDXW-1:0] dst_idx,
  input logic [1:0]      sh_kind,
  input logic [AW-1:0]   sh_amt,
  input logic [DW-1:0]   src_val,
  input logic            carry_in,
  input logic [DW-1:0]   res_q,
  input logic            rf_wr,
  input logic            pc_wr,
  input logic            exc_ret,
  input logic            flg_wr,
  input logic            flg_n,
  input logic            flg_z,
  input logic            flg_c,
  input logic            flg_wr_d,
  input logic [DW-1:0]   sh_res,
  input logic            sh_cout
);
  localparam logic [IDXW-1:0] PC_CODE = IDXW'(PC_IDX);
  localparam logic [AW-1:0]   FULL    = AW'(DW);

  p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !cond_pass |=> !(rf_wr || pc_wr || exc_ret || flg_wr));

  p_one_dest_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_wr, pc_wr, exc_ret}));

  p_pc_plain_r3: assert property (@(posedge clk) disable iff (rst)
    (cond_pass && dst_idx == PC_CODE && !set_flags) |=> (pc_wr && !flg_wr));

  p_exc_ret_r4: assert property (@(posedge clk) disable iff (rst)
    (cond_pass && dst_idx == PC_CODE && set_flags) |=> (exc_ret && !flg_wr));

  p_nz_r5: assert property (@(posedge clk) disable iff (rst)
    flg_wr |-> (flg_n == res_q[DW-1] && flg_z == (res_q == '0)));

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !flg_wr_d |=> $stable({flg_n, flg_z, flg_c}));

  p_zero_amt_r6: assert property (@(posedge clk) disable iff (rst)
    (sh_kind != 2'd3 && sh_amt == '0) |-> (sh_res == src_val && sh_cout == carry_in));

  p_lsr_full_r8: assert property (@(posedge clk) disable iff (rst)
    (sh_kind == 2'd1 && sh_amt == FULL) |-> (sh_res == '0 && sh_cout == src_val[DW-1]));

  p_ror_carry_r10: assert property (@(posedge clk) disable iff (rst)
    (sh_kind == 2'd3 && sh_amt != '0) |-> (sh_cout == sh_res[DW-1]));

  p_rrx_r11: assert property (@(posedge clk) disable iff (rst)
    (sh_kind == 2'd3 && sh_amt == '0) |-> (sh_res == {carry_in, src_val[DW-1:1]} && sh_cout == src_val[0]));

  p_latency_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> res_q == $past(sh_res));

endmodule

bind shift_move_unit shmv_chk #(.DW(DW), .IDXW(IDXW), .PC_IDX(PC_IDX), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cond_pass (cond_pass),
  .set_flags (set_flags),
  .dst_idx   (dst_idx),
  .sh_kind   (sh_kind),
  .sh_amt    (sh_amt),
  .src_val   (src_val),
  .carry_in  (carry_in),
  .res_q     (res_q),
  .rf_wr     (rf_wr),
  .pc_wr     (pc_wr),
  .exc_ret   (exc_ret),
  .flg_wr    (flg_wr),
  .flg_n     (flg_n),
  .flg_z     (flg_z),
  .flg_c     (flg_c),
  .flg_wr_d  (flg_wr_d),
  .sh_res    (sh_res),
  .sh_cout   (sh_cout)
);

// File: tb/sim_shift_move_unit.sv
`timescale 1ns/1ps
module sim_shift_move_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cond_pass = 1'b0;
  logic        set_flags = 1'b0;
  logic [3:0]  dst_idx = '0;
  logic [1:0]  sh_kind = '0;
  logic [5:0]  sh_amt = '0;
  logic [31:0] src_val = '0;
  logic        carry_in = 1'b0;
  logic [31:0] res_q;
  logic        rf_wr, pc_wr, exc_ret, flg_wr, flg_n, flg_z, flg_c;

  int total = 0;
  int bad   = 0;
  logic e_n = 1'b0, e_z = 1'b0, e_c = 1'b0;

  always #2 clk = ~clk;

  shift_move_unit u0 (
    .clk(clk), .rst(rst), .cond_pass(cond_pass), .set_flags(set_flags),
    .dst_idx(dst_idx), .sh_kind(sh_kind), .sh_amt(sh_amt), .src_val(src_val),
    .carry_in(carry_in), .res_q(res_q), .rf_wr(rf_wr), .pc_wr(pc_wr),
    .exc_ret(exc_ret), .flg_wr(flg_wr), .flg_n(flg_n), .flg_z(flg_z), .flg_c(flg_c)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] k, input int n, input logic [31:0] x,
                        input logic ci, input logic sf, input logic [3:0] d,
                        input logic cp, input string rq);
    logic [63:0] w;
    logic [32:0] t;
    logic [31:0] er;
    logic        ec, x_rf, x_pc, x_er, x_fw;
    string       rs;
    case (k)
      2'd0: begin w = {32'b0, x} << n; er = w[31:0]; ec = (n == 0) ? ci : w[32]; end
      2'd1: begin t = {x, 1'b0} >> n; er = t[32:1]; ec = (n == 0) ? ci : t[0]; end
      2'd2: begin t = $unsigned($signed({x, 1'b0}) >>> n); er = t[32:1]; ec = (n == 0) ? ci : t[0]; end
      default: begin
        if (n == 0) begin t = {ci, x}; er = t[32:1]; ec = x[0]; end
        else begin w = {x, x} >> n; er = w[31:0]; ec = er[31]; end
      end
    endcase
    x_rf = cp && d != 4'd15;
    x_pc = cp && d == 4'd15 && !sf;
    x_er = cp && d == 4'd15 && sf;
    x_fw = cp && d != 4'd15 && sf;
    if (x_fw) begin e_n = er[31]; e_z = (er == 32'd0); e_c = ec; end
    rs = !cp ? "R1" : (d == 4'd15) ? (sf ? "R4" : "R3") : "R2";
    @(negedge clk);
    sh_kind = k; sh_amt = 6'(n); src_val = x; carry_in = ci;
    set_flags = sf; dst_idx = d; cond_pass = cp;
    @(negedge clk);
    chk(res_q === er, rq, "result", res_q, er);
    chk({rf_wr, pc_wr, exc_ret, flg_wr} === {x_rf, x_pc, x_er, x_fw}, rs, "strobes",
        32'({rf_wr, pc_wr, exc_ret, flg_wr}), 32'({x_rf, x_pc, x_er, x_fw}));
    chk({flg_n, flg_z} === {e_n, e_z}, "R5", "nz", 32'({flg_n, flg_z}), 32'({e_n, e_z}));
    chk(flg_c === e_c, x_fw ? rq : "R5", "carry", 32'(flg_c), 32'(e_c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0001;
    pats[3] = 32'h7FFF_FFFE; pats[4] = 32'hA5C3_0F96; pats[5] = 32'h0001_0000;
    repeat (3) @(negedge clk);
    chk({res_q, rf_wr, pc_wr, exc_ret, flg_wr, flg_n, flg_z, flg_c} === '0, "R12", "reset",
        res_q, 32'd0);
    rst = 1'b0;
    // Shifter sweep: every legal amount of each kind, flags updated to expose carry.
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n <= ((k == 1 || k == 2) ? 32 : 31); n++) begin
        for (int p = 0; p < 6; p++) begin
          for (int c = 0; c < 2; c++) begin
            string rq;
            if (k != 3 && n == 0) rq = "R6";
            else if (k == 0) rq = "R7";
            else if (k == 1) rq = "R8";
            else if (k == 2) rq = "R9";
            else rq = (n == 0) ? "R11" : "R10";
            run_op(2'(k), n, pats[p], c[0], 1'b1, 4'(3 + p), 1'b1, rq);
          end
        end
      end
    end
    // Commit sweep: every destination against set-flags and condition (R1..R4).
    for (int d = 0; d < 16; d++) begin
      for (int s = 0; s < 2; s++) begin
        for (int cp = 0; cp < 2; cp++) begin
          run_op(2'd1, 4 + d, pats[(d + s) % 6] ^ 32'(cp << d), s[0], s[0], 4'(d), cp[0], "R12");
        end
      end
    end
    // Failed condition after a flag write: flags must hold (R1).
    run_op(2'd0, 0, 32'h8000_0000, 1'b1, 1'b1, 4'd2, 1'b1, "R6");
    run_op(2'd1, 32, 32'h0000_0001, 1'b0, 1'b1, 4'd2, 1'b0, "R1");
    run_op(2'd3, 0, 32'h0000_0001, 1'b0, 1'b1, 4'd15, 1'b1, "R4");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule